// File: doc/BRIEF.md
# Triangular Spread-Spectrum Divide-Word Modulator

This block drives the feedback-divide setting of a fractional-N synthesizer so that the synthesized clock wanders slowly up and down in frequency. Spreading the energy this way lowers the peak emissions of the clock and its harmonics. It takes a nominal divide value, made of an integer word and a 24-bit fraction, and adds a signed triangular offset to it. The offset is added to the integer and fraction as one combined word, so a carry or borrow out of the fraction moves the integer part. The peak offset is given in fraction LSBs. Because the relative divide deviation equals the relative frequency deviation, software picks the peak as the nominal value times the wanted deviation.

One triangle lasts four times the programmed rate divider, counted in reference cycles. The modulation frequency is therefore the reference rate divided by four times that value. Each quarter ramps by peak/rate per cycle. An error-accumulating stepper does the ramp, so every quarter lands exactly on its endpoint. A serial divider splits the peak into a whole step and a remainder, so no parallel divider is needed.

In center mode the offset swings between +peak and −peak. In down mode it swings between 0 and −2·peak. A rate divider below the minimum, or zero, leaves the output at the nominal value. New settings are captured only when a triangle period starts. The output is a plain per-cycle word qualified by an update strobe. It has no handshake and applies no back-pressure: the synthesizer takes the word every cycle.

Top module: `ssm_tri_mod`

## Requirements
- R1: While `rst` is high, and while the block is not running a triangle (disabled, preparing or holding), `{mod_int,mod_frac}` equals the live `{nom_int,nom_frac}` of the previous cycle. `upd_stb` is 0 during reset.
- R2: The block samples all settings and starts a preparation phase on the first enabled edge. The preparation phase lasts PEAK_W+1 cycles, which is 25 at the defaults. The triangle starts on the edge after it. Outputs are registered and trail the internal state by one cycle, so with peak ≥ rate the first output change comes 28 edges after `en` rises.
- R3: In center mode (`down_sel`=0) the offset is built from k (0…D−1, the cycle within the quarter) and m = floor(P·k/D), where P is the peak and D the rate divider. The four quarters are +m, P−m, −m and m−P. One period lasts 4·D cycles.
- R4: In down mode (`down_sel`=1) the four quarters are −m, −P−m, m−2P and m−P. The offset is never positive and reaches −2P.
- R5: The offset is sign-extended and added to the combined word {integer, fraction}, modulo 2^(INT_W+FRAC_W). Fraction overflow increments the integer part, and fraction underflow decrements it.
- R6: A sampled rate divider below MIN_RATE (default 18, so that the modulation rate stays under 1/70 of the reference) is never run. In that case the block stays in preparation, resamples every PEAK_W+1 cycles and outputs the nominal value.
- R7: The nominal words, peak, rate and mode are sampled when a period or preparation starts, and they are used from the next period start. Changes at any other time do not alter the running triangle.
- R8: `upd_stb` is high in exactly those cycles in which `{mod_int,mod_frac}` differs from its value in the previous cycle.
- R9: When `en` is sampled low, the block returns to idle. From the following cycle on the output is the nominal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulation enable |
| nom_int | input | INT_W | Nominal integer divide word |
| nom_frac | input | FRAC_W | Nominal fractional divide word |
| spread_peak | input | PEAK_W | Peak offset in fraction LSBs |
| rate_div | input | RATE_W | Quarter-period length in reference cycles |
| down_sel | input | 1 | 1 selects down spread, 0 selects center spread |
| mod_int | output | INT_W | Modulated integer divide word |
| mod_frac | output | FRAC_W | Modulated fractional divide word |
| upd_stb | output | 1 | High when the output word changed this cycle |

## Verification
The bench uses a peak below the rate divider, so that most steps are zero and the ramp relies on the remainder carry. If the remainder handling is wrong, the quarters end short of or past the peak. A nominal fraction a few LSBs from either end tests carry and borrow into the integer word, which a fraction-only adder would wrap instead. Rates of 0 and 17 must leave the output quiet, and a mid-period settings change must be delayed by one full period. A design that applied it at once would show a kink inside a triangle. The startup latency and the enable drop are timed to the exact edge, which exposes an off-by-one in the preparation count or in the output register.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } ssm_state_e;
endpackage

// File: rtl/ssm_sdiv.sv
// Serial restoring divider: one quotient bit per cycle.
module ssm_sdiv #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_sh;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  assign trial = {rem, num_sh[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};
  assign done  = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      num_sh <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      quo    <= '0;
      rem    <= '0;
    end else if (load) begin
      num_sh <= num;
      den_q  <= den;
      cnt_q  <= CNT_W'(NUM_W);
      quo    <= '0;
      rem    <= '0;
    end else if (!done) begin
      num_sh <= {num_sh[NUM_W-2:0], 1'b0};
      quo    <= {quo[NUM_W-2:0], ge};
      rem    <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    (done && den_q != '0) |-> (rem < den_q)); // R3
endmodule

// File: rtl/ssm_tri_step.sv
// Error-accumulating ramp stepper: quarter index, step index, magnitude.
module ssm_tri_step #(
  parameter int MAG_W  = 24,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  input  logic [RATE_W-1:0] rate,
  input  logic [MAG_W-1:0]  quo,
  input  logic [RATE_W-1:0] rem_in,
  output logic [1:0]        quarter,
  output logic              last_step,
  output logic [MAG_W-1:0]  mag,
  output logic [MAG_W-1:0]  inc
);
  logic [RATE_W-1:0] k_q, err_q;
  logic [RATE_W:0]   esum, enext;
  logic              ecarry;

  assign esum      = {1'b0, err_q} + {1'b0, rem_in};
  assign ecarry    = esum >= {1'b0, rate};
  assign enext     = ecarry ? (esum - {1'b0, rate}) : esum;
  assign inc       = quo + MAG_W'(ecarry);
  assign last_step = (k_q == rate - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      quarter <= '0;
      k_q     <= '0;
      err_q   <= '0;
      mag     <= '0;
    end else if (adv) begin
      if (last_step) begin
        quarter <= quarter + 2'd1;
        k_q     <= '0;
        err_q   <= '0;
        mag     <= '0;
      end else begin
        k_q     <= k_q + 1'b1;
        err_q   <= enext[RATE_W-1:0];
        mag     <= mag + inc;
      end
    end
  end

  AST_ERR_BELOW_RATE: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear) |=> (err_q < rate)); // R3
endmodule

// File: rtl/ssm_tri_mod.sv
module ssm_tri_mod
  import ssm_pkg::*;
#(
  parameter int INT_W    = 12,
  parameter int FRAC_W   = 24,
  parameter int PEAK_W   = 24,
  parameter int RATE_W   = 16,
  parameter int MIN_RATE = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INT_W-1:0]  nom_int,
  input  logic [FRAC_W-1:0] nom_frac,
  input  logic [PEAK_W-1:0] spread_peak,
  input  logic [RATE_W-1:0] rate_div,
  input  logic              down_sel,
  output logic [INT_W-1:0]  mod_int,
  output logic [FRAC_W-1:0] mod_frac,
  output logic              upd_stb
);
  localparam int CW       = INT_W + FRAC_W;
  localparam int OFF_W    = PEAK_W + 3;
  localparam int PREP_LEN = PEAK_W + 1;
  localparam int PC_W     = $clog2(PREP_LEN);
  localparam int MIN_FIT  = (PREP_LEN + 3) / 4;
  localparam int MIN_OK   = (MIN_RATE > MIN_FIT) ? MIN_RATE : MIN_FIT;
  localparam logic [RATE_W-1:0] MIN_RATE_V = RATE_W'(MIN_OK);
  localparam logic [PC_W-1:0]   PC_LAST    = PC_W'(PREP_LEN - 1);

  ssm_state_e        st_q;
  logic [PC_W-1:0]   pc_q;
  logic [CW-1:0]     nxt_nom, cur_nom, live_nom;
  logic [PEAK_W-1:0] nxt_peak, cur_peak, cur_quo, div_quo;
  logic [RATE_W-1:0] nxt_rate, cur_rate, cur_rem, div_rem;
  logic              nxt_down, cur_down, div_done;
  logic              prep_end, run_end, period_evt, nxt_ok;
  logic              sample_now, start_run;
  logic [1:0]        quarter;
  logic              last_step;
  logic [PEAK_W-1:0] mag, inc;

  assign live_nom   = {nom_int, nom_frac};
  assign nxt_ok     = nxt_rate >= MIN_RATE_V;
  assign prep_end   = (st_q == ST_PREP) && (pc_q == PC_LAST);
  assign run_end    = (st_q == ST_RUN) && (quarter == 2'd3) && last_step;
  assign period_evt = prep_end || run_end;
  assign sample_now = en && ((st_q == ST_IDLE) || period_evt);
  assign start_run  = en && period_evt && nxt_ok;

  // Control state
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_q <= ST_PREP;
        ST_PREP: if (prep_end) st_q <= nxt_ok ? ST_RUN : ST_PREP;
        ST_RUN:  if (run_end)  st_q <= nxt_ok ? ST_RUN : ST_PREP;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= (st_q == ST_PREP && !prep_end) ? pc_q + 1'b1 : '0;
  end

  // Settings staging: sampled now, applied at the next period start
  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_nom  <= '0;
      nxt_peak <= '0;
      nxt_rate <= '0;
      nxt_down <= 1'b0;
    end else if (sample_now) begin
      nxt_nom  <= live_nom;
      nxt_peak <= spread_peak;
      nxt_rate <= rate_div;
      nxt_down <= down_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_nom  <= '0;
      cur_peak <= '0;
      cur_rate <= '0;
      cur_down <= 1'b0;
      cur_quo  <= '0;
      cur_rem  <= '0;
    end else if (start_run) begin
      cur_nom  <= nxt_nom;
      cur_peak <= nxt_peak;
      cur_rate <= nxt_rate;
      cur_down <= nxt_down;
      cur_quo  <= div_quo;
      cur_rem  <= div_rem;
    end
  end

  ssm_sdiv #(.NUM_W(PEAK_W), .DEN_W(RATE_W)) div_i (
    .clk  (clk),
    .rst  (rst),
    .load (sample_now),
    .num  (spread_peak),
    .den  (rate_div),
    .quo  (div_quo),
    .rem  (div_rem),
    .done (div_done)
  );

  ssm_tri_step #(.MAG_W(PEAK_W), .RATE_W(RATE_W)) step_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_run),
    .adv       ((st_q == ST_RUN) && !start_run),
    .rate      (cur_rate),
    .quo       (cur_quo),
    .rem_in    (cur_rem),
    .quarter   (quarter),
    .last_step (last_step),
    .mag       (mag),
    .inc       (inc)
  );

  // Offset shaping per quarter and mode
  logic signed [OFF_W-1:0] pk_s, mg_s, off_s;
  logic [CW-1:0]           off_ext, out_next, out_q;

  assign pk_s = signed'({3'b000, cur_peak});
  assign mg_s = signed'({3'b000, mag});

  always_comb begin
    unique case ({cur_down, quarter})
      3'b000:  off_s = mg_s;
      3'b001:  off_s = pk_s - mg_s;
      3'b010:  off_s = -mg_s;
      3'b011:  off_s = mg_s - pk_s;
      3'b100:  off_s = -mg_s;
      3'b101:  off_s = -pk_s - mg_s;
      3'b110:  off_s = mg_s - (pk_s + pk_s);
      default: off_s = mg_s - pk_s;
    endcase
  end

  assign off_ext  = {{(CW - OFF_W){off_s[OFF_W-1]}}, off_s};
  assign out_next = (st_q == ST_RUN) ? (cur_nom + off_ext) : live_nom;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= live_nom;
      upd_stb <= 1'b0;
    end else begin
      out_q   <= out_next;
      upd_stb <= (out_next != out_q);
    end
  end

  assign {mod_int, mod_frac} = out_q;

  AST_IDLE_NOMINAL: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN) |=> ({mod_int, mod_frac} == $past(live_nom))); // R1
  AST_DIV_READY: assert property (@(posedge clk) disable iff (rst)
    start_run |-> div_done); // R2
  AST_MAG_LE_PEAK: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (mag <= cur_peak)); // R3
  AST_QUARTER_LANDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && last_step) |-> (({1'b0, mag} + {1'b0, inc}) == {1'b0, cur_peak})); // R3
  AST_DOWN_NONPOS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && cur_down) |-> (off_s <= 0)); // R4
  AST_RATE_VALID: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (cur_rate >= MIN_RATE_V)); // R6
  AST_CUR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !start_run) |=> ($stable(cur_peak) && $stable(cur_rate) && $stable(cur_down) && $stable(cur_nom))); // R7
  AST_STB_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (upd_stb == ({mod_int, mod_frac} != $past({mod_int, mod_frac})))); // R8
endmodule

// File: tb/ssm_tri_mod_tb_top.sv
`timescale 1ns/1ps
module ssm_tri_mod_tb_top;
  localparam int PREP_LEN = 25;
  localparam int MINR     = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [11:0] nom_int = 12'd50;
  logic [23:0] nom_frac = 24'h100000;
  logic [23:0] spread_peak = 24'd0;
  logic [15:0] rate_div = 16'd0;
  logic        down_sel = 1'b0;
  logic [11:0] mod_int;
  logic [23:0] mod_frac;
  logic        upd_stb;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ssm_tri_mod dut_i (
    .clk(clk), .rst(rst), .en(en), .nom_int(nom_int), .nom_frac(nom_frac),
    .spread_peak(spread_peak), .rate_div(rate_div), .down_sel(down_sel),
    .mod_int(mod_int), .mod_frac(mod_frac), .upd_stb(upd_stb)
  );

  // Reference model state
  int          m_st = 0;  // 0 idle, 1 prep, 2 run
  int          m_pc = 0, m_q = 0, m_k = 0;
  logic [35:0] c_nom = '0, n_nom = '0, prev_out = '0;
  longint      c_peak = 0, c_rate = 1, n_peak = 0, n_rate = 0;
  bit          c_down = 0, n_down = 0;
  string       tag = "R1";

  function automatic logic [35:0] model_out();
    longint m, off;
    logic [63:0] t;
    if (m_st != 2) return {nom_int, nom_frac};
    m = (c_peak * m_k) / c_rate;
    if (!c_down)
      case (m_q)
        0: off = m;
        1: off = c_peak - m;
        2: off = -m;
        default: off = m - c_peak;
      endcase
    else
      case (m_q)
        0: off = -m;
        1: off = -c_peak - m;
        2: off = m - 2 * c_peak;
        default: off = m - c_peak;
      endcase
    t = off;
    return c_nom + t[35:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sample_next();
    n_nom = {nom_int, nom_frac}; n_peak = spread_peak; n_rate = rate_div; n_down = down_sel;
  endtask

  task automatic restart();
    if (n_rate >= MINR) begin
      m_st = 2; c_nom = n_nom; c_peak = n_peak; c_rate = n_rate; c_down = n_down;
      m_q = 0; m_k = 0;
    end else begin
      m_st = 1; m_pc = 0;
    end
    sample_next();
  endtask

  task automatic tick();
    logic [35:0] e;
    bit es;
    e  = rst ? {nom_int, nom_frac} : model_out();
    es = rst ? 1'b0 : (e != prev_out);
    @(posedge clk);
    #1;
    chk(tag, {28'd0, mod_int, mod_frac}, {28'd0, e});
    chk("R8 strobe", {63'd0, upd_stb}, {63'd0, es});
    prev_out = e;
    if (rst || !en) m_st = 0;
    else case (m_st)
      0: begin m_st = 1; m_pc = 0; sample_next(); end
      1: if (m_pc == PREP_LEN - 1) restart(); else m_pc++;
      default: if (m_k == c_rate - 1) begin
                 if (m_q == 3) restart(); else begin m_q++; m_k = 0; end
               end else m_k++;
    endcase
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic setcfg(input logic [23:0] p, input logic [15:0] d, input bit dn);
    spread_peak = p; rate_div = d; down_sel = dn;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit seen_carry, seen_borrow;
    void'($urandom(32'd5821));
    // R1: reset and idle
    tag = "R1 reset";
    run(3);
    chk("R1 reset word", {28'd0, mod_int, mod_frac}, {28'd0, nom_int, nom_frac});
    chk("R1 reset strobe", {63'd0, upd_stb}, 64'd0);
    rst = 1'b0;
    tag = "R1 idle";
    run(3);
    nom_frac = 24'h123456;
    run(4);

    // R2: startup latency to first output change
    tag = "R2 startup";
    setcfg(24'd40000, 16'd20, 1'b0);
    en = 1'b1;
    cnt = 0;
    do begin tick(); cnt++; end while (!upd_stb && cnt < 100);
    chk("R2 first change edge", cnt, 28);
    // R3: center triangle over two periods
    tag = "R3 center";
    run(2 * 4 * 20 + 10);
    // R3: peak below rate, remainder-driven ramp
    setcfg(24'd7, 16'd19, 1'b0);
    tag = "R3 small peak";
    run(3 * 4 * 20 + 30);

    // R7: change settings mid-period
    tag = "R7 change";
    run(13);
    setcfg(24'd90000, 16'd31, 1'b0);
    nom_int = 12'd77;
    run(7);
    setcfg(24'd2000, 16'd24, 1'b1);
    run(4 * 31 + 4 * 24 * 3 + 20);

    // R9: enable drop mid-run
    tag = "R9 disable";
    run(17);
    en = 1'b0;
    run(12);
    chk("R9 nominal after drop", {28'd0, mod_int, mod_frac}, {28'd0, nom_int, nom_frac});

    // R4: down spread
    tag = "R4 down";
    setcfg(24'd5000, 16'd33, 1'b1);
    en = 1'b1;
    run(PREP_LEN + 2 * 4 * 33 + 10);

    // R5: carry and borrow across the fraction boundary
    tag = "R5 carry";
    en = 1'b0; run(2);
    nom_int = 12'd300; nom_frac = 24'hFFFFD8;
    setcfg(24'd1000, 16'd18, 1'b0);
    en = 1'b1;
    seen_carry = 0; seen_borrow = 0;
    for (int i = 0; i < PREP_LEN + 4 * 18 + 5; i++) begin
      tick();
      if (mod_int == 12'd301) seen_carry = 1;
    end
    en = 1'b0; run(2);
    tag = "R5 borrow";
    nom_frac = 24'd30;
    setcfg(24'd1000, 16'd18, 1'b1);
    en = 1'b1;
    for (int i = 0; i < PREP_LEN + 4 * 18 + 5; i++) begin
      tick();
      if (mod_int == 12'd299) seen_borrow = 1;
    end
    chk("R5 carry seen", {63'd0, seen_carry}, 64'd1);
    chk("R5 borrow seen", {63'd0, seen_borrow}, 64'd1);

    // R6: invalid rate dividers hold nominal
    en = 1'b0; run(2);
    tag = "R6 invalid";
    setcfg(24'd50000, 16'd17, 1'b0);
    en = 1'b1;
    run(3);
    cnt = 0;
    for (int i = 0; i < 150; i++) begin tick(); if (upd_stb) cnt++; end
    chk("R6 no change rate 17", cnt, 0);
    rate_div = 16'd0;
    cnt = 0;
    for (int i = 0; i < 150; i++) begin tick(); if (upd_stb) cnt++; end
    chk("R6 no change rate 0", cnt, 0);
    // recovery to a valid rate through resampling
    tag = "R6 recover";
    rate_div = 16'd18;
    run(2 * PREP_LEN + 4 * 18 + 5);

    // Random configurations, center and down
    for (int r = 0; r < 8; r++) begin
      int d;
      en = 1'b0; run(2);
      d = 18 + int'($urandom_range(0, 60));
      nom_int = 12'($urandom);
      nom_frac = 24'($urandom);
      setcfg(24'($urandom) >> $urandom_range(0, 20), 16'(d), 1'($urandom));
      tag = down_sel ? "R4 random" : "R3 random";
      en = 1'b1;
      run(PREP_LEN + 2 * 4 * d + 5);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule